// File: doc/BRIEF.md
# BF16 to FP8 narrowing converter

This block turns two vectors of bfloat16 values into one packed vector of 8-bit floating-point bytes. Each of the `LANES` lanes holds one 16-bit value from a first source and one from a second source. The two converted bytes of a lane sit next to each other in the output, so the results of the two sources alternate byte by byte. A format selector picks the target byte format: a 5-bit exponent with a 2-bit fraction, or a 4-bit exponent with a 3-bit fraction. A signed power-of-two scale is applied to every finite input before rounding, which lets software fold a rescale into the narrowing step. A saturate control decides whether an out-of-range result clamps to the largest finite magnitude.

Each operation is taken with a valid/ready handshake. Its result sits in one output register until the consumer takes it. Exception flags gather the events of every value in every operation and stay set until a clear request arrives. Rounding is always to nearest, with ties going to the even result.

Top module: `bf16_fp8_narrow`

## Requirements
- R1: `fmt_sel` = 0 selects the 5-bit-exponent format (bias 15, largest finite code 0x7B = 57344). `fmt_sel` = 1 selects the 4-bit-exponent format (bias 7, largest finite code 0x7E = 448). Codes 2 and 3 are invalid: every output byte becomes 0xFF and the invalid flag is raised.
- R2: Output byte 2i, at bits [16i+7:16i], is the conversion of lane i of `src_a`. Byte 2i+1 is the conversion of lane i of `src_b`.
- R3: `scale` is a two's-complement value of `SCALE_W` bits (at most 6). It is added to the exponent of every finite non-zero input before rounding, which multiplies the input by 2^scale.
- R4: The result is rounded to nearest with ties to even. A result that differs from the scaled input raises the inexact flag (flag bit 0).
- R5: Results below the normal range are encoded as subnormals with correct rounding. The underflow flag (bit 1) is raised when the scaled value is below the smallest normal before rounding and the result is inexact. An input of zero gives a zero of the same sign. A subnormal bfloat16 input gives a zero of the same sign and raises underflow and inexact.
- R6: When a finite value overflows and `sat_en` is 0, the 5-bit-exponent format gives signed infinity (0x7C with the sign) and the 4-bit-exponent format gives 0x7F. When `sat_en` is 1, both formats give the signed largest finite value. Either way the overflow flag (bit 2) and the inexact flag are raised.
- R7: An infinite input ignores `scale`. In the 5-bit-exponent format it stays signed infinity when `sat_en` is 0 and becomes the signed maximum when `sat_en` is 1, and it raises no flags. In the 4-bit-exponent format it gives the signed maximum with no flags when `sat_en` is 1. When `sat_en` is 0 it gives 0x7F and raises the invalid flag.
- R8: A NaN input gives the default NaN of the target format: 0x7E for 5-bit-exponent, 0x7F for 4-bit-exponent. A signalling NaN (fraction bit 6 clear) also raises the invalid flag (bit 3).
- R9: `flags` = {invalid, overflow, underflow, inexact} on bits 3..0. The flags of an accepted operation are ORed over all its values and into the held flags, on the same edge that loads the result. Without a clear, a flag never drops.
- R10: `flag_clr` zeroes the flags at the next edge. If an operation is accepted on that same edge, the flags afterwards hold only that operation's flags.
- R11: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted operation's result shows on `out_bytes` with `out_valid` one edge later. While `out_valid` is high and `out_ready` is low, both stay unchanged and no new input is taken.
- R12: After reset, `out_valid` is 0 and `flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation |
| src_a | input | LANES*16 | First bfloat16 source vector, lane i at [16i+15:16i] |
| src_b | input | LANES*16 | Second bfloat16 source vector |
| fmt_sel | input | 2 | Target byte format selector |
| scale | input | SCALE_W | Signed power-of-two scale |
| sat_en | input | 1 | Clamp overflow to the largest finite value |
| flag_clr | input | 1 | Clear the sticky exception flags |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_bytes | output | LANES*16 | Interleaved 8-bit results |
| flags | output | 4 | Sticky {invalid, overflow, underflow, inexact} |

## Verification
Clearing the flags and merging a new operation's flags can land on the same clock edge. The bench first sets only the invalid flag with a bad-format operation. It then offers an operation that raises only inexact while `flag_clr` is high in that same cycle. The flags must then read inexact alone: the earlier invalid is gone and the new event is kept. A second overlap checked is an offer arriving while the output is stalled: the held bytes must not change, and the offer is taken on the edge where `out_ready` returns.

// File: rtl/fp8n_pkg.sv
`timescale 1ns/1ps
package fp8n_pkg;

   localparam int FMT_W = 2;
   localparam logic [FMT_W-1:0] FMT_WIDE_EXP = 2'd0;   // 5-bit exponent, 2-bit fraction
   localparam logic [FMT_W-1:0] FMT_WIDE_MAN = 2'd1;   // 4-bit exponent, 3-bit fraction

   // per-format encoding constants (magnitude bits only)
   localparam int          WE_MANT = 2;
   localparam int          WE_BIAS = 15;
   localparam logic [6:0]  WE_MAX  = 7'h7B;
   localparam logic [6:0]  WE_INF  = 7'h7C;
   localparam logic [6:0]  WE_NAN  = 7'h7E;

   localparam int          WM_MANT = 3;
   localparam int          WM_BIAS = 7;
   localparam logic [6:0]  WM_MAX  = 7'h7E;
   localparam logic [6:0]  WM_NAN  = 7'h7F;

   localparam int SHIFT_CAP = 24;   // right shift beyond this leaves only sticky bits

   typedef struct packed {
      logic iv;   // invalid
      logic of;   // overflow
      logic uf;   // underflow
      logic nx;   // inexact
   } fp8n_flags_t;

endpackage

// File: rtl/fp8n_cvt.sv
`timescale 1ns/1ps
module fp8n_cvt
   import fp8n_pkg::*;
#(
   parameter int         MANT_W  = 2,
   parameter int         BIAS    = 15,
   parameter logic [6:0] MAX_MAG = 7'h7B,
   parameter bit         HAS_INF = 1'b1,
   parameter logic [6:0] INF_MAG = 7'h7C,
   parameter logic [6:0] NAN_MAG = 7'h7E,
   parameter int         SCALE_W = 6
) (
   input  logic [15:0]        x,
   input  logic [SCALE_W-1:0] scale,
   input  logic               sat,
   output logic [7:0]         y,
   output fp8n_flags_t        fl
);

   localparam int EW = 12;
   localparam int XW = 32;
   localparam int KW = MANT_W + 1;
   localparam logic signed [EW-1:0] BOFF = EW'(BIAS - 127);
   localparam logic [6:0] OVF_MAG = HAS_INF ? INF_MAG : NAN_MAG;
   localparam bit OVF_SIGNED = HAS_INF;

   if (MANT_W < 1 || MANT_W > 5) begin : g_bad_mant
      $error("fp8n_cvt: MANT_W out of range");
   end
   if (SCALE_W < 2 || SCALE_W > 6) begin : g_bad_scale
      $error("fp8n_cvt: SCALE_W out of range");
   end

   logic              sgn;
   logic [7:0]        ex;
   logic [6:0]        mt;
   logic              is_nan, is_inf, is_zsub;
   logic signed [EW-1:0] scl_ext, te;
   logic              tiny;
   logic [4:0]        sh;
   logic [XW-1:0]     ext;
   logic [KW-1:0]     keep;
   logic              grd, stk, up;
   logic [EW-1:0]     ebase, code;
   logic              ovf;
   logic [7:0]        ovf_y;
   logic [7:0]        inf_y;
   logic              inf_iv;

   assign sgn     = x[15];
   assign ex      = x[14:7];
   assign mt      = x[6:0];
   assign is_nan  = (ex == 8'hFF) && (mt != 7'd0);
   assign is_inf  = (ex == 8'hFF) && (mt == 7'd0);
   assign is_zsub = (ex == 8'h00);

   assign scl_ext = {{(EW-SCALE_W){scale[SCALE_W-1]}}, scale};
   assign te      = $signed({4'b0000, ex}) + scl_ext + BOFF;
   assign tiny    = (te <= 12'sd0);

   always_comb begin
      if (!tiny)
         sh = 5'd0;
      else if (te < -12'sd23)
         sh = 5'(SHIFT_CAP);
      else
         sh = 5'(12'sd1 - te);
   end

   assign ext   = {1'b1, mt, 24'd0} >> sh;
   assign keep  = ext[XW-1 -: KW];
   assign grd   = ext[XW-1-KW];
   assign stk   = |ext[XW-2-KW:0];
   assign up    = grd & (stk | keep[0]);
   assign ebase = tiny ? '0 : EW'(te - 12'sd1);
   // the hidden bit of keep carries the exponent up by one, and so does a rounding carry
   assign code  = (ebase << MANT_W) + EW'(keep) + EW'(up);
   assign ovf   = code > EW'(MAX_MAG);
   assign ovf_y = sat ? {sgn, MAX_MAG} : {sgn & OVF_SIGNED, OVF_MAG};

   if (HAS_INF) begin : g_inf_enc
      assign inf_y  = sat ? {sgn, MAX_MAG} : {sgn, INF_MAG};
      assign inf_iv = 1'b0;
   end else begin : g_no_inf_enc
      assign inf_y  = sat ? {sgn, MAX_MAG} : {1'b0, NAN_MAG};
      assign inf_iv = ~sat;
   end

   always_comb begin
      fl = '0;
      if (is_nan) begin
         y     = {1'b0, NAN_MAG};
         fl.iv = ~mt[6];
      end else if (is_inf) begin
         y     = inf_y;
         fl.iv = inf_iv;
      end else if (is_zsub) begin
         y     = {sgn, 7'd0};
         fl.uf = (mt != 7'd0);
         fl.nx = (mt != 7'd0);
      end else if (ovf) begin
         y     = ovf_y;
         fl.of = 1'b1;
         fl.nx = 1'b1;
      end else begin
         y     = {sgn, code[6:0]};
         fl.nx = grd | stk;
         fl.uf = tiny & (grd | stk);
      end
   end

   always_comb begin
      // R6
      if (sat && !is_nan)
         sat_clamp_chk: assert (y[6:0] <= MAX_MAG);
      // R8
      if (is_nan)
         nan_default_chk: assert (y == {1'b0, NAN_MAG} && !fl.of && !fl.nx);
   end

endmodule

// File: rtl/fp8n_lane.sv
`timescale 1ns/1ps
module fp8n_lane
   import fp8n_pkg::*;
#(
   parameter int SCALE_W = 6
) (
   input  logic [15:0]        a_val,
   input  logic [15:0]        b_val,
   input  logic [FMT_W-1:0]   fmt,
   input  logic [SCALE_W-1:0] scale,
   input  logic               sat,
   output logic [15:0]        byte_pair,
   output fp8n_flags_t        fl
);

   localparam int NSRC = 2;

   fp8n_flags_t fl_vec [NSRC];

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [15:0] xin;
      logic [7:0]  y_we, y_wm, y_sel;
      fp8n_flags_t f_we, f_wm, f_sel;

      assign xin = (s == 0) ? a_val : b_val;

      fp8n_cvt #(
         .MANT_W (WE_MANT), .BIAS(WE_BIAS), .MAX_MAG(WE_MAX),
         .HAS_INF(1'b1), .INF_MAG(WE_INF), .NAN_MAG(WE_NAN), .SCALE_W(SCALE_W)
      ) u_wide_exp (
         .x(xin), .scale(scale), .sat(sat), .y(y_we), .fl(f_we)
      );

      fp8n_cvt #(
         .MANT_W (WM_MANT), .BIAS(WM_BIAS), .MAX_MAG(WM_MAX),
         .HAS_INF(1'b0), .INF_MAG(WM_NAN), .NAN_MAG(WM_NAN), .SCALE_W(SCALE_W)
      ) u_wide_man (
         .x(xin), .scale(scale), .sat(sat), .y(y_wm), .fl(f_wm)
      );

      always_comb begin
         case (fmt)
            FMT_WIDE_EXP: begin y_sel = y_we; f_sel = f_we; end
            FMT_WIDE_MAN: begin y_sel = y_wm; f_sel = f_wm; end
            default: begin
               y_sel = 8'hFF;
               f_sel = '{iv: 1'b1, default: 1'b0};
            end
         endcase
      end

      assign byte_pair[8*s +: 8] = y_sel;
      assign fl_vec[s]           = f_sel;
   end

   assign fl = fl_vec[0] | fl_vec[1];

endmodule

// File: rtl/fp8n_flag_acc.sv
`timescale 1ns/1ps
module fp8n_flag_acc
   import fp8n_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc,
   input  logic        clr,
   input  fp8n_flags_t new_fl,
   output fp8n_flags_t flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else if (clr || acc)
         flags <= (clr ? '0 : flags) | (acc ? new_fl : '0);
   end

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !acc) |=> (flags == '0));

   // R9
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/bf16_fp8_narrow.sv
`timescale 1ns/1ps
module bf16_fp8_narrow
   import fp8n_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int SCALE_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [LANES*16-1:0]  src_a,
   input  logic [LANES*16-1:0]  src_b,
   input  logic [1:0]           fmt_sel,
   input  logic [SCALE_W-1:0]   scale,
   input  logic                 sat_en,
   input  logic                 flag_clr,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [LANES*16-1:0]  out_bytes,
   output logic [3:0]           flags
);

   localparam int VW = LANES * 16;

   if (LANES < 1) begin : g_bad_lanes
      $error("bf16_fp8_narrow: LANES must be at least 1");
   end
   if (SCALE_W < 2 || SCALE_W > 6) begin : g_bad_scale
      $error("bf16_fp8_narrow: SCALE_W must be 2..6");
   end

   logic [VW-1:0] out_nxt;
   fp8n_flags_t   lane_fl [LANES];
   fp8n_flags_t   op_fl;
   fp8n_flags_t   flags_q;
   logic          accept;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fp8n_lane #(.SCALE_W(SCALE_W)) u_lane (
         .a_val     (src_a[16*i +: 16]),
         .b_val     (src_b[16*i +: 16]),
         .fmt       (fmt_sel),
         .scale     (scale),
         .sat       (sat_en),
         .byte_pair (out_nxt[16*i +: 16]),
         .fl        (lane_fl[i])
      );
   end

   always_comb begin
      op_fl = '0;
      for (int i = 0; i < LANES; i++)
         op_fl = op_fl | lane_fl[i];
   end

   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_bytes <= '0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_bytes <= out_nxt;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   fp8n_flag_acc u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (accept),
      .clr    (flag_clr),
      .new_fl (op_fl),
      .flags  (flags_q)
   );

   assign flags = flags_q;

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bytes)));

   // R1
   bad_fmt_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && fmt_sel[1]) |=> ((&out_bytes) && flags[3]));

   // R11
   load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

endmodule

// File: tb/tb_bf16_fp8_narrow.sv
`timescale 1ns/1ps
module tb_bf16_fp8_narrow;

   localparam int LANES   = 4;
   localparam int SCALE_W = 6;
   localparam int VW      = LANES * 16;
   localparam int NV      = 33;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [VW-1:0] src_a = '0;
   logic [VW-1:0] src_b = '0;
   logic [1:0]    fmt_sel = 2'd0;
   logic [SCALE_W-1:0] scale = '0;
   logic          sat_en = 1'b0;
   logic          flag_clr = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [VW-1:0] out_bytes;
   logic [3:0]    flags;

   always #4 clk = ~clk;

   bf16_fp8_narrow #(.LANES(LANES), .SCALE_W(SCALE_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .src_a(src_a), .src_b(src_b), .fmt_sel(fmt_sel), .scale(scale),
      .sat_en(sat_en), .flag_clr(flag_clr), .out_valid(out_valid),
      .out_ready(out_ready), .out_bytes(out_bytes), .flags(flags)
   );

   // {fmt, scale, sat, bf16 in, expected byte, expected flags}
   localparam logic [36:0] VEC [NV] = '{
      {2'd0, 6'h00, 1'b0, 16'h3F80, 8'h3C, 4'h0},  // R1
      {2'd1, 6'h00, 1'b0, 16'h3F80, 8'h38, 4'h0},  // R1
      {2'd0, 6'h02, 1'b0, 16'h3F80, 8'h44, 4'h0},  // R3
      {2'd1, 6'h3D, 1'b0, 16'h3FC0, 8'h24, 4'h0},  // R3
      {2'd1, 6'h37, 1'b0, 16'h3F80, 8'h01, 4'h0},  // R3
      {2'd0, 6'h00, 1'b0, 16'h3F90, 8'h3C, 4'h1},  // R4 tie, even kept
      {2'd0, 6'h00, 1'b0, 16'h3FB0, 8'h3E, 4'h1},  // R4 tie, rounds up
      {2'd0, 6'h00, 1'b0, 16'h3F98, 8'h3D, 4'h1},  // R4 above tie
      {2'd1, 6'h00, 1'b0, 16'h43E8, 8'h7E, 4'h1},  // R4 largest finite
      {2'd0, 6'h00, 1'b0, 16'h4780, 8'h7C, 4'h5},  // R6
      {2'd0, 6'h00, 1'b1, 16'h4780, 8'h7B, 4'h5},  // R6
      {2'd0, 6'h00, 1'b1, 16'hC780, 8'hFB, 4'h5},  // R6
      {2'd1, 6'h00, 1'b0, 16'h4400, 8'h7F, 4'h5},  // R6
      {2'd1, 6'h00, 1'b1, 16'h4400, 8'h7E, 4'h5},  // R6
      {2'd1, 6'h00, 1'b0, 16'h43F0, 8'h7F, 4'h5},  // R6 overflow by rounding
      {2'd1, 6'h1F, 1'b1, 16'h3F80, 8'h7E, 4'h5},  // R6 via scale
      {2'd0, 6'h05, 1'b0, 16'h7F80, 8'h7C, 4'h0},  // R7
      {2'd0, 6'h00, 1'b1, 16'hFF80, 8'hFB, 4'h0},  // R7
      {2'd1, 6'h00, 1'b0, 16'h7F80, 8'h7F, 4'h8},  // R7
      {2'd1, 6'h00, 1'b1, 16'hFF80, 8'hFE, 4'h0},  // R7
      {2'd0, 6'h00, 1'b0, 16'h7FC0, 8'h7E, 4'h0},  // R8
      {2'd0, 6'h00, 1'b0, 16'h7F81, 8'h7E, 4'h8},  // R8
      {2'd1, 6'h00, 1'b1, 16'hFFC0, 8'h7F, 4'h0},  // R8
      {2'd0, 6'h00, 1'b0, 16'h3800, 8'h02, 4'h0},  // R5
      {2'd0, 6'h00, 1'b0, 16'h37C0, 8'h02, 4'h3},  // R5
      {2'd0, 6'h00, 1'b0, 16'h3580, 8'h00, 4'h3},  // R5
      {2'd0, 6'h00, 1'b0, 16'hB580, 8'h80, 4'h3},  // R5
      {2'd0, 6'h00, 1'b0, 16'h387F, 8'h04, 4'h3},  // R5
      {2'd0, 6'h00, 1'b0, 16'h8000, 8'h80, 4'h0},  // R5
      {2'd1, 6'h00, 1'b0, 16'h0001, 8'h00, 4'h3},  // R5
      {2'd0, 6'h20, 1'b0, 16'h3F80, 8'h00, 4'h3},  // R3
      {2'd2, 6'h00, 1'b0, 16'h3F80, 8'hFF, 4'h8},  // R1
      {2'd3, 6'h00, 1'b1, 16'h7FC0, 8'hFF, 4'h8}   // R1
   };

   int n_chk  = 0;
   int n_fail = 0;

   function automatic string tag_of(input int k);
      if (k <= 1)  return "R1";
      if (k <= 4)  return "R3";
      if (k <= 8)  return "R4";
      if (k <= 15) return "R6";
      if (k <= 19) return "R7";
      if (k <= 22) return "R8";
      if (k <= 29) return "R5";
      if (k == 30) return "R3";
      return "R1";
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] f, input logic [5:0] s, input logic st,
                        input logic [VW-1:0] a, input logic [VW-1:0] b, input logic clr);
      @(negedge clk);
      fmt_sel = f; scale = s; sat_en = st; src_a = a; src_b = b;
      flag_clr = clr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 out_valid", 64'(out_valid), 64'd0);
      chk("R12 flags", 64'(flags), 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         logic [36:0] e;
         logic [VW-1:0] expb;
         e = VEC[k];
         pulse_clr();
         do_op(e[36:35], e[34:29], e[28], {LANES{e[27:12]}}, '0, 1'b0);
         expb = (e[36:35] > 2'd1) ? {VW{1'b1}} : {LANES{8'h00, e[11:4]}};
         chk({tag_of(k), " bytes"}, 64'(out_bytes), 64'(expb));
         chk({tag_of(k), " flags"}, 64'(flags), 64'(e[3:0]));
         chk("R11 valid after accept", 64'(out_valid), 64'd1);
      end

      // R2 interleave of the two sources
      pulse_clr();
      do_op(2'd0, 6'h00, 1'b0, {16'hBF80, 16'h4080, 16'h4000, 16'h3F80},
            {16'h7FC0, 16'hC000, 16'h3F00, 16'h0000}, 1'b0);
      chk("R2 interleave", 64'(out_bytes), 64'h7EBC_C044_3840_003C);
      chk("R2 flags", 64'(flags), 64'd0);

      // R9 OR across lanes and sources
      pulse_clr();
      do_op(2'd0, 6'h00, 1'b0, {48'd0, 16'h4780}, {32'd0, 16'h7F81, 16'd0}, 1'b0);
      chk("R9 lane OR bytes", 64'(out_bytes), 64'h0000_0000_7E00_007C);
      chk("R9 lane OR flags", 64'(flags), 64'hD);

      // R9 sticky: inexact stays through an exact operation
      pulse_clr();
      do_op(2'd0, 6'h00, 1'b0, {LANES{16'h3F90}}, '0, 1'b0);
      do_op(2'd0, 6'h00, 1'b0, {LANES{16'h3F80}}, '0, 1'b0);
      chk("R9 sticky flags", 64'(flags), 64'h1);
      chk("R9 sticky bytes", 64'(out_bytes), {LANES{16'h003C}});

      // R10 clear alone
      pulse_clr();
      chk("R10 clear alone", 64'(flags), 64'd0);

      // R10 clear on the same edge as an accepted operation
      do_op(2'd2, 6'h00, 1'b0, '0, '0, 1'b0);
      chk("R10 pre flags", 64'(flags), 64'h8);
      do_op(2'd0, 6'h00, 1'b0, {LANES{16'h3F90}}, '0, 1'b1);
      chk("R10 clear plus accept", 64'(flags), 64'h1);

      // R11 back-pressure
      @(negedge clk); out_ready = 1'b0;
      do_op(2'd0, 6'h00, 1'b0, {LANES{16'h3F80}}, '0, 1'b0);
      @(negedge clk);
      fmt_sel = 2'd0; src_a = {LANES{16'h4000}}; src_b = '0; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 stall valid", 64'(out_valid), 64'd1);
      chk("R11 stall ready", 64'(in_ready), 64'd0);
      chk("R11 stall bytes", 64'(out_bytes), {LANES{16'h003C}});
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R11 release bytes", 64'(out_bytes), {LANES{16'h0040}});
      chk("R11 release valid", 64'(out_valid), 64'd1);
      @(negedge clk);
      chk("R11 drain", 64'(out_valid), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule